// File: doc/BRIEF.md
# Current-Mode PWM Timing Generator

This block decides when the gate of a flyback power switch is requested on and off in a peak-current-mode controller. A free-running period counter opens every switching cycle with a turn-on edge. The pulse then ends at whichever comes first: a trip from the current-sense comparator once its blanking window has closed, or a hard cap of three quarters of the period. In normal operation the period length follows a slow triangular sweep around its nominal value, which spreads the switching spectrum.

A feedback code, taken from the error amplifier level, selects the operating regime once per period. A high code gives normal dithered switching. A middle band gives a fixed, much longer green-mode period. A low code gives burst operation, in which whole periods pass without a pulse. The same code also picks a short or a long blanking window for the sense input. A run enable masks the gate at once. When the enable returns, a fresh period starts.

Top module: `pwm_timing_gen`

## Requirements
- R1: While reset is asserted, and afterwards while run_en stays low, gate_req is 0.
- R2: In normal mode the period is NOM_PERIOD (200) plus an offset. The offset starts at 0 and moves up by 1 every DITHER_DIV period starts. It turns down on reaching +DITHER_SPAN (12) and turns up again on reaching -DITHER_SPAN, so the period stays within 188 to 212 cycles.
- R3: With no sense trip, gate_req stays high for exactly P - floor(P/4) clock cycles of each period of length P, starting in the period's first cycle.
- R4: If cs_trip or ilim_trip is high at a clock edge where the in-period count k is at least the blanking length, gate_req goes low after that edge (pulse width k+1) and stays low for the rest of the period.
- R5: A trip seen while the count is below the blanking length has no effect. The blanking length is 4 cycles when fb_code >= 76 and 10 cycles when fb_code < 76.
- R6: When fb_code < 94 (and >= 56) at a period start, that period lasts GREEN_PERIOD (591) cycles with no dither offset, and its pulse cap is 444 cycles.
- R7: When fb_code < 56 at a period start, gate_req stays low for that whole period of 591 cycles. Pulses resume at the first period start that sees fb_code >= 56.
- R8: Period length, blanking length and regime are sampled only at a period start. A change of fb_code during a period does not alter that period.
- R9: gate_req follows a low run_en in the same cycle. On the first clock edge with run_en high again, a new period starts from count 0, with gate_req high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (13 MHz in the intended use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Switching allowed when high |
| fb_code | input | 8 | Feedback level code, about 40 codes per volt |
| cs_trip | input | 1 | Peak-current comparator has tripped |
| ilim_trip | input | 1 | Absolute current-limit comparator has tripped |
| gate_req | output | 1 | Gate on request to the driver |

## Verification
Two functions can act in the same clock cycle. The first pair is the end of the blanking window and a sense trip: a trip held high from the turn-on edge must end the pulse exactly at count blank, giving widths of 5 and 11 cycles. The second pair is the duty cap and a trip in green mode: a trip placed at count 443, the last cycle the cap allows, and one placed at count 444 must both give a 444-cycle pulse. The scenarios are driven by timing the trip against the observed rising edge of gate_req and measuring the width of the resulting high run.

// File: rtl/pwm_timing_pkg.sv
package pwm_timing_pkg;

    // Operating regime chosen at each period start
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_GREEN = 2'd1,
        MODE_SKIP  = 2'd2
    } sw_mode_e;

endpackage

// File: rtl/pwm_dither.sv
module pwm_dither #(
    parameter int NOM_PERIOD  = 200,
    parameter int DITHER_SPAN = 12,
    parameter int DITHER_DIV  = 16,
    parameter int PER_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [PER_W-1:0] period_o
);
    localparam int OFS_W = $clog2(DITHER_SPAN + 1) + 1;
    localparam int DIV_W = (DITHER_DIV > 1) ? $clog2(DITHER_DIV) : 1;
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(DITHER_SPAN);
    localparam logic [OFS_W-1:0] OFS_MIN = OFS_W'(-DITHER_SPAN);

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             up;
        logic [DIV_W-1:0] div;
    } dith_state_t;

    dith_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (st_q.div == DIV_W'(DITHER_DIV - 1)) begin
                st_d.div = '0;
                if (st_q.up) begin
                    st_d.ofs = st_q.ofs + 1'b1;
                    if (st_q.ofs + 1'b1 == OFS_MAX) st_d.up = 1'b0;
                end else begin
                    st_d.ofs = st_q.ofs - 1'b1;
                    if (st_q.ofs - 1'b1 == OFS_MIN) st_d.up = 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ofs <= '0;
            st_q.up  <= 1'b1;
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic signed [PER_W:0] sum;
    always_comb begin
        sum      = $signed((PER_W+1)'(NOM_PERIOD)) + (PER_W+1)'($signed(st_q.ofs));
        period_o = sum[PER_W-1:0];
    end

    // R2: the offset never leaves the sweep band
    p_dither_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(st_q.ofs) <= $signed(OFS_MAX)) && ($signed(st_q.ofs) >= $signed(OFS_MIN)));

    // R2: the offset only moves on a period start, and by one unit
    p_dither_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ofs != $past(st_q.ofs)) |->
            ($past(step_i) && ((st_q.ofs - $past(st_q.ofs) == OFS_W'(1)) ||
                               ($past(st_q.ofs) - st_q.ofs == OFS_W'(1)))));

endmodule

// File: rtl/pwm_mode_sel.sv
module pwm_mode_sel
    import pwm_timing_pkg::*;
#(
    parameter int FB_W         = 8,
    parameter int PER_W        = 10,
    parameter int BLK_W        = 4,
    parameter int GREEN_PERIOD = 591,
    parameter int SHORT_BLANK  = 4,
    parameter int LONG_BLANK   = 10,
    parameter int GREEN_TH     = 94,
    parameter int BURST_TH     = 56,
    parameter int BLANK_TH     = 76
) (
    input  logic [FB_W-1:0]  fb_code,
    input  logic [PER_W-1:0] norm_period,
    output sw_mode_e         mode_o,
    output logic [PER_W-1:0] period_o,
    output logic [BLK_W-1:0] blank_o
);
    localparam logic [FB_W-1:0] TH_GREEN = FB_W'(GREEN_TH);
    localparam logic [FB_W-1:0] TH_BURST = FB_W'(BURST_TH);
    localparam logic [FB_W-1:0] TH_BLANK = FB_W'(BLANK_TH);

    always_comb begin
        if (fb_code < TH_BURST) begin
            mode_o   = MODE_SKIP;
            period_o = PER_W'(GREEN_PERIOD);
        end else if (fb_code < TH_GREEN) begin
            mode_o   = MODE_GREEN;
            period_o = PER_W'(GREEN_PERIOD);
        end else begin
            mode_o   = MODE_RUN;
            period_o = norm_period;
        end
        blank_o = (fb_code >= TH_BLANK) ? BLK_W'(SHORT_BLANK) : BLK_W'(LONG_BLANK);
    end

endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
    parameter int PER_W       = 10,
    parameter int BLK_W       = 4,
    parameter int NOM_PERIOD  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sense_trip,
    input  logic [PER_W-1:0] sel_period,
    input  logic [BLK_W-1:0] sel_blank,
    input  logic             sel_skip,
    output logic             start_o,
    output logic             gate_o
);
    localparam logic [PER_W-1:0] RST_PER = PER_W'(NOM_PERIOD);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] ton;
        logic [BLK_W-1:0] blank;
        logic             skip;
        logic             gate;
        logic             active;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        if (!run_en) begin
            st_d.cnt    = '0;
            st_d.gate   = 1'b0;
            st_d.active = 1'b0;
        end else if (!st_q.active || (st_q.cnt == st_q.per - 1'b1)) begin
            start_o     = 1'b1;
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.per    = sel_period;
            st_d.ton    = sel_period - (sel_period >> 2);
            st_d.blank  = sel_blank;
            st_d.skip   = sel_skip;
            st_d.gate   = !sel_skip;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.gate) begin
                if (st_q.cnt + 1'b1 >= st_q.ton) begin
                    st_d.gate = 1'b0;
                end else if (sense_trip && (st_q.cnt >= PER_W'(st_q.blank))) begin
                    st_d.gate = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.per    <= RST_PER;
            st_q.ton    <= RST_PER - (RST_PER >> 2);
            st_q.blank  <= '0;
            st_q.skip   <= 1'b0;
            st_q.gate   <= 1'b0;
            st_q.active <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate & run_en;

    // R3: the pulse never runs past the duty cap
    p_duty_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |-> (st_q.cnt < st_q.ton));

    // R4: an unblanked trip ends the pulse at the next edge
    p_trip_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.gate && sense_trip && (st_q.cnt >= PER_W'(st_q.blank))) |=> !st_q.gate);

    // R5: inside the blanking window the pulse survives
    p_blank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.gate && (st_q.cnt + 1'b1 < PER_W'(st_q.blank))) |=> st_q.gate);

    // R7: a skipped period carries no pulse
    p_skip_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.skip |-> !st_q.gate);

    // R8: period settings move only at a period start
    p_period_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.per != $past(st_q.per)) || (st_q.blank != $past(st_q.blank))) |-> (st_q.cnt == '0));

    // R9: a low enable clears the counter and the gate
    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ((st_q.cnt == '0) && !st_q.gate && !gate_o));

endmodule

// File: rtl/pwm_timing_gen.sv
module pwm_timing_gen
    import pwm_timing_pkg::*;
#(
    parameter int FB_W         = 8,
    parameter int NOM_PERIOD   = 200,
    parameter int DITHER_SPAN  = 12,
    parameter int DITHER_DIV   = 16,
    parameter int GREEN_PERIOD = 591,
    parameter int SHORT_BLANK  = 4,
    parameter int LONG_BLANK   = 10,
    parameter int GREEN_TH     = 94,
    parameter int BURST_TH     = 56,
    parameter int BLANK_TH     = 76
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic [FB_W-1:0] fb_code,
    input  logic            cs_trip,
    input  logic            ilim_trip,
    output logic            gate_req
);
    localparam int PER_W = $clog2(GREEN_PERIOD + 1);
    localparam int BLK_W = $clog2(LONG_BLANK + 1);

    logic             start;
    logic [PER_W-1:0] norm_period;
    logic [PER_W-1:0] sel_period;
    logic [BLK_W-1:0] sel_blank;
    sw_mode_e         sel_mode;
    logic             sense_trip;

    assign sense_trip = cs_trip | ilim_trip;

    pwm_dither #(
        .NOM_PERIOD  (NOM_PERIOD),
        .DITHER_SPAN (DITHER_SPAN),
        .DITHER_DIV  (DITHER_DIV),
        .PER_W       (PER_W)
    ) u_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (start),
        .period_o (norm_period)
    );

    pwm_mode_sel #(
        .FB_W         (FB_W),
        .PER_W        (PER_W),
        .BLK_W        (BLK_W),
        .GREEN_PERIOD (GREEN_PERIOD),
        .SHORT_BLANK  (SHORT_BLANK),
        .LONG_BLANK   (LONG_BLANK),
        .GREEN_TH     (GREEN_TH),
        .BURST_TH     (BURST_TH),
        .BLANK_TH     (BLANK_TH)
    ) u_mode (
        .fb_code     (fb_code),
        .norm_period (norm_period),
        .mode_o      (sel_mode),
        .period_o    (sel_period),
        .blank_o     (sel_blank)
    );

    pwm_gate_seq #(
        .PER_W      (PER_W),
        .BLK_W      (BLK_W),
        .NOM_PERIOD (NOM_PERIOD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .sense_trip (sense_trip),
        .sel_period (sel_period),
        .sel_blank  (sel_blank),
        .sel_skip   (sel_mode == MODE_SKIP),
        .start_o    (start),
        .gate_o     (gate_req)
    );

    // R1: no gate request while held in reset
    always_comb begin
        if (!rst_n) p_reset_quiet_r1: assert (!gate_req);
    end

endmodule

// File: tb/pwm_timing_gen_test.sv
module pwm_timing_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [7:0] fb_code = 8'd200;
    logic       cs_trip = 1'b0;
    logic       ilim_trip = 1'b0;
    logic       gate_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_timing_gen #(.DITHER_DIV(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .fb_code   (fb_code),
        .cs_trip   (cs_trip),
        .ilim_trip (ilim_trip),
        .gate_req  (gate_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at a rise sample (count 0); returns at the next rise sample.
    // kind: 0 none, 1 cs_trip, 2 ilim_trip; len 0 holds the trip.
    task automatic measure(input int kind, input int at, input int len,
                           input int fb_at, input logic [7:0] fb_val,
                           output int hi, output int per);
        int  i;
        logic prev, inp;
        hi = 0; per = 0; i = 0; inp = 1'b1;
        while (i < 3000) begin
            if (inp && gate_req) hi++; else inp = 1'b0;
            if (i == at) begin
                if (kind == 1) cs_trip = 1'b1;
                if (kind == 2) ilim_trip = 1'b1;
            end
            if (len > 0 && i == at + len) begin cs_trip = 1'b0; ilim_trip = 1'b0; end
            if (i == fb_at) fb_code = fb_val;
            prev = gate_req;
            @(negedge clk);
            i++; per++;
            if (gate_req && !prev) break;
        end
        cs_trip = 1'b0; ilim_trip = 1'b0;
    endtask

    task automatic wait_rise(input int limit, output bit found);
        logic prev;
        found = 1'b0;
        prev = gate_req;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (gate_req && !prev) begin found = 1'b1; break; end
            prev = gate_req;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(gate_req == 1'b0, "R1 in reset", gate_req, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (gate_req) chk(1'b0, "R1 idle after reset", gate_req, 0);
        end
        chk(gate_req == 1'b0, "R1 idle after reset", gate_req, 0);
    endtask

    task automatic t_dither();
        int d, up, dv, hi, per;
        d = 0; up = 1; dv = 0;
        run_en = 1'b1;
        @(negedge clk);
        chk(gate_req == 1'b1, "R9 start on enable", gate_req, 1);
        for (int k = 0; k < 30; k++) begin
            measure(0, -1, 0, -1, 8'd0, hi, per);
            chk(per == 200 + d, "R2 dithered period", per, 200 + d);
            chk(hi == per - per / 4, "R3 duty cap", hi, per - per / 4);
            if (dv == 1) begin
                dv = 0;
                if (up == 1) begin d++; if (d == 12) up = 0; end
                else begin d--; if (d == -12) up = 1; end
            end else dv++;
        end
    endtask

    task automatic t_trip_normal();
        int hi, per;
        measure(1, 50, 1, -1, 8'd0, hi, per);
        chk(hi == 51, "R4 cs trip at count 50", hi, 51);
        measure(2, 30, 1, -1, 8'd0, hi, per);
        chk(hi == 31, "R4 limit trip at count 30", hi, 31);
        measure(1, 3, 1, -1, 8'd0, hi, per);
        chk(hi == per - per / 4, "R5 trip in short blank ignored", hi, per - per / 4);
        measure(1, 0, 0, -1, 8'd0, hi, per);
        chk(hi == 5, "R5 short blank expiry with held trip", hi, 5);
    endtask

    task automatic t_latch_green();
        int hi, per;
        measure(0, -1, 0, 20, 8'd80, hi, per);
        chk(per >= 188 && per <= 212, "R8 period kept after mid-period change", per, 200);
        chk(hi == per - per / 4, "R8 cap kept after mid-period change", hi, per - per / 4);
        measure(0, -1, 0, -1, 8'd0, hi, per);
        chk(per == 591, "R6 green period", per, 591);
        chk(hi == 444, "R6 green cap", hi, 444);
        measure(1, 443, 1, -1, 8'd0, hi, per);
        chk(hi == 444, "R4 trip on last capped cycle", hi, 444);
        chk(per == 591, "R6 green period undithered", per, 591);
        measure(1, 444, 1, -1, 8'd0, hi, per);
        chk(hi == 444, "R3 trip after cap", hi, 444);
    endtask

    task automatic t_long_blank();
        int hi, per;
        fb_code = 8'd60;
        measure(0, -1, 0, -1, 8'd0, hi, per);
        chk(per == 591, "R6 green period at code 60", per, 591);
        measure(1, 0, 0, -1, 8'd0, hi, per);
        chk(hi == 11, "R5 long blank expiry with held trip", hi, 11);
        measure(2, 8, 1, -1, 8'd0, hi, per);
        chk(hi == 444, "R5 trip in long blank ignored", hi, 444);
    endtask

    task automatic t_burst();
        bit found;
        int seen;
        fb_code = 8'd30;
        repeat (600) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (gate_req) seen++;
        end
        chk(seen == 0, "R7 burst skips pulses", seen, 0);
        fb_code = 8'd200;
        wait_rise(700, found);
        chk(found == 1'b1, "R7 pulses resume", found, 1);
    endtask

    task automatic t_enable();
        int hi, per, seen;
        repeat (10) @(negedge clk);
        run_en = 1'b0;
        #1;
        chk(gate_req == 1'b0, "R9 same-cycle mask", gate_req, 0);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (gate_req) seen++;
        end
        chk(seen == 0, "R9 held low while disabled", seen, 0);
        run_en = 1'b1;
        @(negedge clk);
        chk(gate_req == 1'b1, "R9 restart on enable", gate_req, 1);
        measure(0, -1, 0, -1, 8'd0, hi, per);
        chk(per >= 188 && per <= 212, "R9 fresh period length", per, 200);
        chk(hi == per - per / 4, "R9 fresh pulse full width", hi, per - per / 4);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_dither();
        t_trip_normal();
        t_latch_green();
        t_long_blank();
        t_burst();
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule